// File: doc/BRIEF.md
# Write-Only Serial Register Target

This block is a target on a two-wire serial bus (I2C) that accepts writes and nothing else. A fast system clock samples the bus clock and data lines. Both lines pass through flop synchronisers, and every bus event is then found in the system clock domain. After a START, the target compares the whole first byte with its fixed address byte. When that byte matches, it takes a register-address byte and then any number of data bytes, until a STOP or a new START arrives.

Each data byte that is accepted appears on a small internal write port. The port carries a register address, a data byte and a write strobe that lasts one cycle. Surrounding logic uses this port to load its registers. The target answers each byte it accepts by pulling the data line low through an open-drain enable. It does not answer any other byte.

The register pointer starts at the value of the register-address byte. It moves up by one after every data byte that the target acknowledges, and it wraps at the top of its range. The system clock must run at no less than sixteen times the bus clock rate. With a 400 kHz bus, this is 6.4 MHz or more.

Top module: `i2c_wr_target`

## Requirements
- R1: The first byte after a START is acknowledged only when all eight bits equal 0xA8 (device address 0x54, direction bit 0). Any other first byte gets no acknowledge. In that case the rest of the transfer, up to the next START, is ignored: no acknowledge and no write strobe.
- R2: A first byte whose direction bit (bit 0) is 1 is never acknowledged, including 0xA9.
- R3: Every byte (address, register address and data) is shifted in most significant bit first. A data bit is taken on the rising edge of the bus clock.
- R4: A falling data line while the bus clock is high is a START. A rising data line while the bus clock is high is a STOP. A STOP returns the target to idle.
- R5: After each accepted byte, the pull-low output asserts while the bus clock is low, before the ninth clock pulse. It holds through that pulse and releases when the bus clock next falls. At no other time is it asserted.
- R6: For each accepted data byte, write strobe is high for exactly one system clock. It rises when the eighth data bit is captured, before the acknowledge pulse. Register address and data are valid with it.
- R7: The first data byte is written at the register-address byte's value. Each later data byte in the same transfer is written one address higher, modulo 256 (0xFF is followed by 0x00).
- R8: A START or STOP that arrives part way through a byte discards the partial byte and produces no strobe. After a START, the target goes back to matching the address byte.
- R9: While reset is asserted, and right after it is released, the pull-low output and the write strobe are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | Active-high enable that pulls the data line low |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 8 | Data byte of the current write |
| wr_en_o | output | 1 | One-cycle write strobe |

## Verification
Two things can land in the same system cycle. A START or STOP can be detected while a byte is only partly shifted in. The top-priority condition handling must then discard the shift state in that cycle, so that no stale strobe or acknowledge survives. The bench provokes this by cutting off a data byte after four bits with a repeated START, and another after three bits with a STOP. Each time, it runs a good transfer straight after. The reference model queues only the writes it expects. Every clock, it judges both the strobe contents and that the pull-low is high only inside acknowledge windows.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   // Which byte of a transfer the target is currently receiving.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DEV  = 2'd1,
      PH_REG  = 2'd2,
      PH_DATA = 2'd3
   } i2cw_phase_e;

   localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2cw_cond.sv
module i2cw_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   // Bus clock stays high across two samples; the data line moves between them.
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
   import i2cw_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h54,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   output logic              sda_pull,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_en
);
   localparam int unsigned CNT_W    = $clog2(BYTE_BITS + 1);
   localparam logic [7:0]  DEV_BYTE = {DEV_ADDR, 1'b0};

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_BITS) begin : g_bad_addr_w
         $error("i2cw_fsm: ADDR_W must be 1..8");
      end
   endgenerate

   i2cw_phase_e       phase;
   logic [CNT_W-1:0]  bit_cnt;
   logic [7:0]        shreg;
   logic              in_ack, ack_ok;
   logic [ADDR_W-1:0] ptr;
   logic              byte_done;
   logic [7:0]        shnext;

   assign byte_done = (bit_cnt == CNT_W'(BYTE_BITS));
   assign shnext    = {shreg[6:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         in_ack   <= 1'b0;
         ack_ok   <= 1'b0;
         ptr      <= '0;
         sda_pull <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         wr_en    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (bus_start) begin
            // Any START, repeated or not, restarts address matching.
            phase    <= PH_DEV;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            ack_ok   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (bus_stop) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            ack_ok   <= 1'b0;
            sda_pull <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise && !byte_done) begin
               shreg   <= shnext;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
                  unique case (phase)
                     PH_DEV:  ack_ok <= (shnext == DEV_BYTE);
                     PH_REG: begin
                        ack_ok <= 1'b1;
                        ptr    <= shnext[ADDR_W-1:0];
                     end
                     PH_DATA: begin
                        ack_ok  <= 1'b1;
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shnext;
                     end
                     default: ack_ok <= 1'b0;
                  endcase
               end
            end else if (scl_fall && byte_done && !in_ack) begin
               if (ack_ok) begin
                  sda_pull <= 1'b1;
                  in_ack   <= 1'b1;
               end else begin
                  phase <= PH_IDLE;
               end
            end else if (scl_fall && in_ack) begin
               sda_pull <= 1'b0;
               in_ack   <= 1'b0;
               ack_ok   <= 1'b0;
               bit_cnt  <= '0;
               unique case (phase)
                  PH_DEV:  phase <= PH_REG;
                  PH_REG:  phase <= PH_DATA;
                  PH_DATA: ptr   <= ptr + 1'b1;
                  default: phase <= PH_IDLE;
               endcase
            end
         end
      end
   end

   // R6: the strobe never lasts longer than one cycle
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R6: the strobe follows a rising bus clock, so the clock is still high
   a_r6_strobe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> scl_s);

   // R5: the pull-low starts only while the bus clock is low
   a_r5_pull_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_s);

   // R5: the pull-low ends on a low bus clock or on a bus condition
   a_r5_pull_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> (!scl_s || $past(bus_start || bus_stop)));

   // R4 / R8: a STOP leaves neither pull-low nor strobe behind
   a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (!sda_pull && !wr_en));
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target #(
   parameter logic [6:0]  DEV_ADDR    = 7'h54,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_en_o
);
   localparam int unsigned N_LINES = 2;

   logic [N_LINES-1:0] raw_lines, sync_lines;
   logic scl_rise, scl_fall, bus_start, bus_stop;

   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_sync
         i2cw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
         );
      end
   endgenerate

   i2cw_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (sync_lines[1]),
      .sda_s    (sync_lines[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop)
   );

   i2cw_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (sync_lines[1]),
      .sda_s    (sync_lines[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .sda_pull (sda_pull_o),
      .wr_addr  (wr_addr_o),
      .wr_data  (wr_data_o),
      .wr_en    (wr_en_o)
   );
endmodule

// File: tb/i2c_wr_target_test.sv
module i2c_wr_target_test;
   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 5;   // system clocks per quarter bus period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1;
   logic sda_drv = 1'b1;
   logic sda_pull, wr_en;
   logic [7:0] wr_addr, wr_data;
   logic sda_line;

   int checks = 0;
   int fails = 0;
   int strobes = 0;
   int model_ptr = 0;
   bit ack_win = 1'b0;
   bit finished = 1'b0;
   logic [15:0] expq[$];

   assign sda_line = sda_drv & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_wr_target uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_drv),
      .sda_i     (sda_line),
      .sda_pull_o(sda_pull),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .wr_en_o   (wr_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model: every strobe is compared with the head of the queue of expected writes.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (wr_en) begin
            strobes++;
            if (expq.size() == 0) chk(1'b0, "R6 unexpected strobe", {wr_addr, wr_data}, 0);
            else begin
               logic [15:0] e;
               e = expq.pop_front();
               chk({wr_addr, wr_data} == e, "R7 write address/data", {wr_addr, wr_data}, e);
            end
         end
         if (sda_pull && !ack_win) chk(1'b0, "R5 pull outside ack window", 1, 0);
      end
   end

   task automatic qwait();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; qwait();
      scl_drv = 1'b1; qwait();
      sda_drv = 1'b0; qwait();
      scl_drv = 1'b0; qwait();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qwait();
      scl_drv = 1'b1; qwait();
      sda_drv = 1'b1; qwait();
      qwait();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n, input bit open_ack);
      for (int i = 0; i < n; i++) begin
         sda_drv = b[7-i]; qwait();
         scl_drv = 1'b1;   qwait(); qwait();
         if (open_ack && i == n - 1) ack_win = 1'b1;
         scl_drv = 1'b0;   qwait();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit is_data,
                            input string req);
      int s0;
      s0 = strobes;
      send_bits(b, 8, 1'b1);
      if (is_data) chk(strobes == s0 + (exp_ack ? 1 : 0), "R6 strobe before ack",
                       strobes - s0, exp_ack ? 1 : 0);
      sda_drv = 1'b1; qwait();
      scl_drv = 1'b1; qwait();
      chk(sda_pull == exp_ack, req, sda_pull, exp_ack);
      qwait();
      scl_drv = 1'b0; qwait();
      ack_win = 1'b0;
      chk(!sda_pull, "R5 release after ack pulse", sda_pull, 0);
   endtask

   task automatic open_write(input logic [7:0] reg_addr);
      bus_start();
      send_byte(8'hA8, 1'b1, 1'b0, "R1 R4 address ack");
      send_byte(reg_addr, 1'b1, 1'b0, "R5 register byte ack");
      model_ptr = reg_addr;
   endtask

   task automatic write_data(input logic [7:0] d);
      expq.push_back({model_ptr[7:0], d});
      send_byte(d, 1'b1, 1'b1, "R3 data byte ack");
      model_ptr = (model_ptr + 1) & 8'hFF;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(!sda_pull && !wr_en, "R9 outputs during reset", {sda_pull, wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sda_pull && !wr_en, "R9 outputs after reset", {sda_pull, wr_en}, 0);
      qwait();

      // Single write
      open_write(8'h05);
      write_data(8'h3C);
      bus_stop();

      // Burst with bit patterns that expose the bit order (R3) and pointer steps (R7)
      open_write(8'h10);
      write_data(8'hA5);
      write_data(8'h5A);
      write_data(8'h00);
      write_data(8'hFF);
      write_data(8'h81);
      bus_stop();

      // Wrong address: no ack, later bytes ignored (R1)
      bus_start();
      send_byte(8'hAA, 1'b0, 1'b0, "R1 foreign address nack");
      send_byte(8'h05, 1'b0, 1'b1, "R1 ignored after nack");
      send_byte(8'h66, 1'b0, 1'b1, "R1 ignored after nack");
      bus_stop();
      bus_start();
      send_byte(8'h28, 1'b0, 1'b0, "R1 msb differs nack");
      bus_stop();

      // Read request never acknowledged (R2)
      bus_start();
      send_byte(8'hA9, 1'b0, 1'b0, "R2 read request nack");
      send_byte(8'h01, 1'b0, 1'b1, "R2 ignored after read nack");
      bus_stop();

      // Pointer wrap (R7)
      open_write(8'hFF);
      write_data(8'h11);
      write_data(8'h22);
      bus_stop();

      // Repeated START mid data byte (R8)
      open_write(8'h20);
      send_bits(8'hC0, 4, 1'b0);
      bus_start();
      send_byte(8'hA8, 1'b1, 1'b0, "R8 address after repeated START");
      send_byte(8'h30, 1'b1, 1'b0, "R8 register after repeated START");
      model_ptr = 8'h30;
      write_data(8'h77);
      bus_stop();

      // STOP mid data byte (R8), then a fresh transfer
      open_write(8'h40);
      send_bits(8'hF0, 3, 1'b0);
      bus_stop();
      chk(!sda_pull, "R8 idle after mid-byte STOP", sda_pull, 0);
      open_write(8'h41);
      write_data(8'h99);
      bus_stop();

      // STOP straight after the address byte (R4)
      bus_start();
      send_byte(8'hA8, 1'b1, 1'b0, "R4 address ack before STOP");
      bus_stop();
      open_write(8'h07);
      write_data(8'hE1);
      bus_stop();

      repeat (10) @(negedge clk);
      chk(expq.size() == 0, "R8 every expected write seen", expq.size(), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule